// File: doc/BRIEF.md
# Pisano End-Around-Carry Word Scrambler

This block scrambles or descrambles one data word per clock for a serial link. A pair of state words advances like a Fibonacci sequence. The sum of the two words goes back into the pair, and the carry out of that sum is kept and added in on the next step, so the carry wraps around from one step to the next. Each data word is combined with one state word and the stored carry by modular addition when scrambling. The same datapath subtracts them when descrambling, which recovers the original word exactly.

A scrambled word leaves with two marker bits. The first marker hides the data/control flag under a key built from the parity of the plain word and the top state bit. The second marker carries the same flag under a key taken only from the state, which acts as a running check. A receiver in descramble mode recovers the flag from the first marker and compares it against the second. A one-cycle error pulse marks any word whose markers disagree. Transmitter and receiver must start from the same seed and must accept the same sequence of words.

Top module: `peac_scrambler`

## Requirements
- R1: While rst_n is low, dout, dout_mark, dout_ctrl, dout_valid and err are 0, and the state is loaded with the seed (X = SEED_X, default 16'h1234; Y = SEED_Y, default 16'hABCD; carry C = 0). The first accepted scramble word of 0 therefore produces dout = SEED_X.
- R2: For each accepted word (en high), the state steps as follows: new X = Y; {new C, new Y} = X + Y + C, with the sum taken W+1 bits wide.
- R3: While en is low, the state and the dout, dout_mark and dout_ctrl registers keep their values, and dout_valid and err are 0 on the next cycle.
- R4: In scramble mode (descramble = 0), one cycle after an accepted word, dout = (din + X + C) mod 2^W, and dout_valid = 1.
- R5: In descramble mode (descramble = 1), one cycle after an accepted word, dout = (din − X − C) mod 2^W.
- R6: When a scrambler's output words and markers drive a descrambler that has the same seed, the descrambler returns the original data word and control flag.
- R7: In scramble mode, dout_ctrl = din_ctrl. dout_mark[0] = din_ctrl ^ parity(din) ^ X[W-1], and dout_mark[1] = din_ctrl ^ Y[0] ^ C.
- R8: In descramble mode, let P be the recovered word. Then dout_ctrl = din_mark[0] ^ parity(P) ^ X[W-1], and dout_mark = din_mark. err is 1 for exactly that cycle when din_mark[1] ^ Y[0] ^ C differs from dout_ctrl. err is never 1 in scramble mode.
- R9: The state never reaches all zeros (X = 0, Y = 0, C = 0). A stream of zero data words therefore yields a changing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Word accepted this cycle; advances the state |
| descramble | input | 1 | 0 = scramble, 1 = descramble |
| din | input | W | Data word in |
| din_ctrl | input | 1 | Control-word flag (scramble mode) |
| din_mark | input | 2 | Received marker bits (descramble mode) |
| dout | output | W | Scrambled or recovered word |
| dout_mark | output | 2 | Generated markers or received markers passed through |
| dout_ctrl | output | 1 | Control flag sent or recovered |
| dout_valid | output | 1 | dout holds a new word |
| err | output | 1 | Marker check mismatch pulse |

## Verification
The receiver's error path is hard to reach from the ports, because a clean link never raises err. A corruption that flips both markers looks like a clean word but inverts the recovered flag. The bench chains a second instance behind the scrambler and XORs random marker corruptions, both single and double, into the link. The expected pulse is the XOR of the two flipped bits. Long random runs with mixed modes and gaps in en drive the state through the cycles where the stored carry is set. This exercises the wrap-around of the modular combination.

// File: rtl/peac_pkg.sv
package peac_pkg;
  typedef enum logic {
    MODE_SCR = 1'b0,
    MODE_DES = 1'b1
  } peac_mode_e;

  localparam int unsigned MARK_W = 2;
endpackage

// File: rtl/peac_state.sv
module peac_state #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SEED_X = 16'h1234,
  parameter logic [W-1:0] SEED_Y = 16'hABCD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         c
);
  logic [W:0]   sum;
  logic [W-1:0] x_d, y_d;
  logic         c_d;

  always_comb begin
    sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    x_d = x;
    y_d = y;
    c_d = c;
    if (adv) begin
      x_d = y;
      y_d = sum[W-1:0];
      c_d = sum[W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= SEED_X;
      y <= SEED_Y;
      c <= 1'b0;
    end else begin
      x <= x_d;
      y <= y_d;
      c <= c_d;
    end
  end

  // R3: a held word leaves the state untouched
  a_r3_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(x) && $stable(y) && $stable(c)));

  // R2: the old Y moves into X on each step
  a_r2_x_takes_y: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (x == $past(y)));

  // R9: the all-zero state is never entered
  a_r9_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ((|x) || (|y) || c));
endmodule

// File: rtl/peac_combine.sv
module peac_combine
  import peac_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  peac_mode_e   mode,
  input  logic [W-1:0] din,
  input  logic [W-1:0] key,
  input  logic         cin,
  output logic [W-1:0] dout
);
  logic [W-1:0] cin_w;

  always_comb begin
    cin_w = {{(W-1){1'b0}}, cin};
    if (mode == MODE_DES) dout = din - key - cin_w;
    else                  dout = din + key + cin_w;
  end
endmodule

// File: rtl/peac_marker.sv
module peac_marker
  import peac_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  peac_mode_e          mode,
  input  logic [W-1:0]        plain,
  input  logic                ctrl_in,
  input  logic [MARK_W-1:0]   mark_in,
  input  logic                x_msb,
  input  logic                y_lsb,
  input  logic                c,
  output logic [MARK_W-1:0]   mark_out,
  output logic                ctrl_out,
  output logic                mismatch
);
  logic k_ctl, k_chk;

  always_comb begin
    k_ctl = (^plain) ^ x_msb;
    k_chk = y_lsb ^ c;
    if (mode == MODE_DES) begin
      ctrl_out = mark_in[0] ^ k_ctl;
      mark_out = mark_in;
      mismatch = (mark_in[1] ^ k_chk) != ctrl_out;
    end else begin
      ctrl_out = ctrl_in;
      mark_out = {ctrl_in ^ k_chk, ctrl_in ^ k_ctl};
      mismatch = 1'b0;
    end
  end
endmodule

// File: rtl/peac_scrambler.sv
module peac_scrambler
  import peac_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SEED_X = 16'h1234,
  parameter logic [W-1:0] SEED_Y = 16'hABCD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         descramble,
  input  logic [W-1:0] din,
  input  logic         din_ctrl,
  input  logic [1:0]   din_mark,
  output logic [W-1:0] dout,
  output logic [1:0]   dout_mark,
  output logic         dout_ctrl,
  output logic         dout_valid,
  output logic         err
);
  peac_mode_e  mode;
  logic [W-1:0] x, y, comb_out, plain;
  logic         c;
  logic [MARK_W-1:0] mark_c;
  logic         ctrl_c, mism_c;

  logic [W-1:0] dout_d;
  logic [1:0]   mark_d;
  logic         ctrl_d, valid_d, err_d;

  assign mode = peac_mode_e'(descramble);

  peac_state #(.W(W), .SEED_X(SEED_X), .SEED_Y(SEED_Y)) u_state (
    .clk(clk), .rst_n(rst_n), .adv(en), .x(x), .y(y), .c(c)
  );

  peac_combine #(.W(W)) u_comb (
    .mode(mode), .din(din), .key(x), .cin(c), .dout(comb_out)
  );

  assign plain = (mode == MODE_DES) ? comb_out : din;

  peac_marker #(.W(W)) u_mark (
    .mode(mode), .plain(plain), .ctrl_in(din_ctrl), .mark_in(din_mark),
    .x_msb(x[W-1]), .y_lsb(y[0]), .c(c),
    .mark_out(mark_c), .ctrl_out(ctrl_c), .mismatch(mism_c)
  );

  always_comb begin
    dout_d  = dout;
    mark_d  = dout_mark;
    ctrl_d  = dout_ctrl;
    valid_d = en;
    err_d   = 1'b0;
    if (en) begin
      dout_d = comb_out;
      mark_d = mark_c;
      ctrl_d = ctrl_c;
      err_d  = mism_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_mark  <= '0;
      dout_ctrl  <= 1'b0;
      dout_valid <= 1'b0;
      err        <= 1'b0;
    end else begin
      dout       <= dout_d;
      dout_mark  <= mark_d;
      dout_ctrl  <= ctrl_d;
      dout_valid <= valid_d;
      err        <= err_d;
    end
  end

  // R8: error pulses only for an accepted descramble word
  a_r8_err_needs_des: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && descramble) |=> !err);

  // R3: idle cycle gives no valid and keeps the data word
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!dout_valid && $stable(dout) && $stable(dout_mark)));

  // R7: scramble mode forwards the control flag
  a_r7_ctrl_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !descramble) |=> (dout_ctrl == $past(din_ctrl)));

  // R4: accepted word is flagged valid next cycle
  a_r4_valid: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> dout_valid);
endmodule

// File: tb/peac_scrambler_test.sv
`timescale 1ns/1ps
module peac_scrambler_test;
  localparam int unsigned W = 16;
  localparam logic [W-1:0] SX = 16'h1234;
  localparam logic [W-1:0] SY = 16'hABCD;

  logic clk = 1'b0;
  logic rst_n;
  logic en, descramble, din_ctrl;
  logic [W-1:0] din;
  logic [1:0] din_mark;
  logic [W-1:0] dout;
  logic [1:0] dout_mark;
  logic dout_ctrl, dout_valid, err;

  logic [W-1:0] rx_dout;
  logic [1:0] rx_mark;
  logic rx_ctrl, rx_valid, rx_err;
  logic [1:0] flip_cur;

  int checks = 0;
  int fails = 0;
  bit rt_phase = 1'b0;

  always #4 clk = ~clk;

  peac_scrambler #(.W(W), .SEED_X(SX), .SEED_Y(SY)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .descramble(descramble), .din(din),
    .din_ctrl(din_ctrl), .din_mark(din_mark), .dout(dout), .dout_mark(dout_mark),
    .dout_ctrl(dout_ctrl), .dout_valid(dout_valid), .err(err)
  );

  peac_scrambler #(.W(W), .SEED_X(SX), .SEED_Y(SY)) rx (
    .clk(clk), .rst_n(rst_n), .en(dout_valid), .descramble(1'b1), .din(dout),
    .din_ctrl(1'b0), .din_mark(dout_mark ^ flip_cur), .dout(rx_dout),
    .dout_mark(rx_mark), .dout_ctrl(rx_ctrl), .dout_valid(rx_valid), .err(rx_err)
  );

  // reference model
  logic [W-1:0] mx, my;
  logic mc;
  logic [W-1:0] e_dout;
  logic [1:0] e_mark;
  logic e_ctrl, e_valid, e_err;
  logic [W+2:0] rtq[$];

  function automatic logic [W-1:0] f_scr(input logic [W-1:0] d, k, input logic ci);
    return d + k + {{(W-1){1'b0}}, ci};
  endfunction
  function automatic logic [W-1:0] f_des(input logic [W-1:0] d, k, input logic ci);
    return d - k - {{(W-1){1'b0}}, ci};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit e, input bit m, input logic [W-1:0] d,
                      input bit ct, input logic [1:0] mk, input logic [1:0] fl);
    logic [W:0] s;
    logic [W-1:0] p;
    logic [W+2:0] q;
    @(negedge clk);
    en = e; descramble = m; din = d; din_ctrl = ct; din_mark = mk;
    e_valid = e;
    e_err = 1'b0;
    if (e) begin
      if (!m) begin
        e_dout = f_scr(d, mx, mc);
        e_mark = {ct ^ my[0] ^ mc, ct ^ (^d) ^ mx[W-1]};
        e_ctrl = ct;
        if (rt_phase) rtq.push_back({fl, ct, d});
      end else begin
        p = f_des(d, mx, mc);
        e_dout = p;
        e_mark = mk;
        e_ctrl = mk[0] ^ (^p) ^ mx[W-1];
        e_err = (mk[1] ^ my[0] ^ mc) != e_ctrl;
      end
      s = {1'b0, mx} + {1'b0, my} + {{W{1'b0}}, mc};
      mx = my; my = s[W-1:0]; mc = s[W];
    end
    @(posedge clk);
    #1;
    flip_cur = e ? fl : 2'b00;
    check(dout_valid == e_valid, e ? "R4 valid" : "R3 valid low", dout_valid, e_valid);
    check(dout == e_dout, m ? "R5 dout" : (e ? "R4 dout" : "R3 hold dout"), dout, e_dout);
    check(dout_mark == e_mark, m ? "R8 mark pass" : "R7 mark", dout_mark, e_mark);
    check(dout_ctrl == e_ctrl, m ? "R8 ctrl" : "R7 ctrl", dout_ctrl, e_ctrl);
    check(err == e_err, "R8 err", err, e_err);
    if (rt_phase && rx_valid) begin
      q = rtq.pop_front();
      check(rx_dout == q[W-1:0], "R6 data", rx_dout, q[W-1:0]);
      check(rx_ctrl == (q[W] ^ q[W+1]), "R6 ctrl", rx_ctrl, q[W] ^ q[W+1]);
      check(rx_err == (q[W+1] ^ q[W+2]), "R8 link err", rx_err, q[W+1] ^ q[W+2]);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    int changes;
    logic [31:0] r;
    void'($urandom(32'h5eed_0042));
    en = 0; descramble = 0; din = '0; din_ctrl = 0; din_mark = '0; flip_cur = '0;
    rst_n = 1'b0;
    mx = SX; my = SY; mc = 1'b0;
    e_dout = '0; e_mark = '0; e_ctrl = 0; e_valid = 0; e_err = 0;
    repeat (3) @(posedge clk);
    #1;
    check(dout == '0 && dout_mark == '0 && !dout_ctrl, "R1 reset data", dout, 0);
    check(!dout_valid && !err, "R1 reset flags", {dout_valid, err}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    rt_phase = 1'b1;
    step(1, 0, '0, 0, 2'b00, 2'b00);
    check(dout == SX, "R1 seed", dout, SX);
    step(1, 0, 16'hFFFF, 1, 2'b00, 2'b00);
    step(1, 0, 16'h0000, 0, 2'b00, 2'b01);
    step(1, 0, 16'hFFFF, 0, 2'b00, 2'b10);
    step(1, 0, 16'h8000, 1, 2'b00, 2'b11);
    for (int i = 0; i < 600; i++) begin
      r = $urandom;
      step(r[0] | r[1], 0, W'($urandom), r[2],
           2'b00, (r[5:3] == 3'd0) ? r[7:6] : 2'b00);
    end
    step(0, 0, '0, 0, 2'b00, 2'b00);
    step(0, 0, '0, 0, 2'b00, 2'b00);
    rt_phase = 1'b0;

    // R3: idle with changing inputs, then resume
    for (int i = 0; i < 5; i++) step(0, i[0], W'($urandom), 1, 2'b11, 2'b00);
    step(1, 0, 16'h5A5A, 0, 2'b00, 2'b00);

    // mixed modes
    for (int i = 0; i < 3000; i++) begin
      r = $urandom;
      step(r[0] | r[1] | r[2], r[3], W'($urandom), r[4], r[6:5], 2'b00);
    end

    // R9: zero stream keeps changing
    changes = 0;
    prev = dout;
    for (int i = 0; i < 64; i++) begin
      step(1, 0, '0, 0, 2'b00, 2'b00);
      if (dout != prev) changes++;
      prev = dout;
    end
    check(changes > 32, "R9 zero stream varies", changes, 33);

    summary();
    $finish;
  end
endmodule